// File: doc/BRIEF.md
# Flash Erase Command Sequence Decoder

This block sits on the write side of a parallel flash controller and watches the write strobe, address and data. It looks for the six-write unlock sequence that asks for an erase. Two kinds of erase are recognised: one that clears the whole array and one that clears a single sector. When the last write of a valid sequence finishes, the block sends a one-clock start pulse to the erase engine. For a sector erase it also reports the index of the selected sector.

The write strobe is active low and arrives without a clock. It passes through a two-flop synchroniser, and its falling and rising edges are then detected in the system clock domain. Address and data are sampled on the falling edge. The sequence advances, and the final command takes effect, on the rising edge.

Only the low `CMP_BITS` address bits take part in the unlock compares. The top `SECT_BITS` bits name the sector.

While the erase engine reports busy, decoding is held off. From the whole-array start pulse until the engine reports done, every write is ignored. The done input also returns the decoder to its idle step.

Top module: `flash_erase_seq`

## Requirements
- R1: The whole-array erase pulse `chip_go` is asserted only after six consecutive writes with these low-address/data pairs: 0x555/0xAA, 0x2AA/0x55, 0x555/0x80, 0x555/0xAA, 0x2AA/0x55, 0x555/0x10.
- R2: If the sixth write carries data 0x30 at any address, the block instead asserts `sect_go`. `sect_id` then equals the top `SECT_BITS` bits of that write's address. `chip_go` and `sect_go` are never high together.
- R3: The sector index is taken from the address present on the falling edge of the sixth strobe. An address change while the strobe is low has no effect on it.
- R4: A start pulse lasts exactly one clock. It does not appear while the sixth strobe is still low, and it appears within four clocks of that strobe's rising edge.
- R5: A write whose pair does not match the expected step returns the decoder to the first step with no pulse. A later complete sequence is still accepted.
- R6: From `chip_go` until `eng_done`, all writes are ignored, including a complete sector-erase sequence.
- R7: While `eng_busy` is high, writes do not advance the sequence and no start pulse is produced.
- R8: `eng_done` returns a partially entered sequence to the first step.
- R9: After reset, `chip_go` and `sect_go` are low and `sect_id` is zero.
- R10: Address bits above the low `CMP_BITS` bits do not affect the unlock compares.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| we_n | input | 1 | Active-low write strobe, asynchronous to clk |
| addr | input | ADDR_W | Write address (sector bits on top) |
| data | input | 8 | Write data |
| eng_busy | input | 1 | Erase engine busy; holds off decoding |
| eng_done | input | 1 | Erase engine finished; returns decoder to idle |
| chip_go | output | 1 | One-clock start pulse for whole-array erase |
| sect_go | output | 1 | One-clock start pulse for sector erase |
| sect_id | output | SECT_BITS | Index of the sector selected by the last sector erase |

## Verification
A wrong step count or a bad compare shows up at the ports within four clocks of the sixth strobe rising. Depending on the fault, that is a missing start pulse, a pulse that should not be there, or a pulse of the wrong kind. A stale run flag or a step that is not reset shows up as an ignored sequence, or as a sequence that is accepted too early, on the very next erase attempt. The bench walks a mismatch through every step position, sweeps every sector index with noisy upper address bits on the unlock writes, and moves the address after the falling edge to show where the sector index is captured.

// File: rtl/flash_erase_seq.sv
module flash_erase_seq #(
  parameter int CMP_BITS  = 11,
  parameter int SECT_BITS = 3,
  parameter int ADDR_W    = CMP_BITS + SECT_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [7:0]           data,
  input  logic                 eng_busy,
  input  logic                 eng_done,
  output logic                 chip_go,
  output logic                 sect_go,
  output logic [SECT_BITS-1:0] sect_id
);
  localparam logic [CMP_BITS-1:0] A_HI = CMP_BITS'('h555);
  localparam logic [CMP_BITS-1:0] A_LO = CMP_BITS'('h2AA);

  logic [2:0]           we_sh;
  logic [CMP_BITS-1:0]  cap_lo;
  logic [SECT_BITS-1:0] cap_sec;
  logic [7:0]           cap_d;
  logic [2:0]           step;
  logic                 chip_run;
  logic                 hit, is_chip, is_sect;

  wire fall = we_sh[2] & ~we_sh[1];
  wire rise = ~we_sh[2] & we_sh[1];
  wire hold = eng_busy | chip_run;

  always_comb begin
    hit = 1'b0;
    case (step)
      3'd0, 3'd3: hit = (cap_lo == A_HI) && (cap_d == 8'hAA);
      3'd1, 3'd4: hit = (cap_lo == A_LO) && (cap_d == 8'h55);
      3'd2:       hit = (cap_lo == A_HI) && (cap_d == 8'h80);
      default:    hit = 1'b0;
    endcase
  end

  assign is_chip = (step == 3'd5) && (cap_lo == A_HI) && (cap_d == 8'h10);
  assign is_sect = (step == 3'd5) && (cap_d == 8'h30);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_sh   <= '1;
      cap_lo  <= '0;
      cap_sec <= '0;
      cap_d   <= '0;
    end else begin
      we_sh <= {we_sh[1:0], we_n};
      if (fall) begin
        cap_lo  <= addr[CMP_BITS-1:0];
        cap_sec <= addr[ADDR_W-1 -: SECT_BITS];
        cap_d   <= data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step     <= '0;
      chip_run <= 1'b0;
      chip_go  <= 1'b0;
      sect_go  <= 1'b0;
      sect_id  <= '0;
    end else begin
      chip_go <= 1'b0;
      sect_go <= 1'b0;
      if (eng_done) begin
        step     <= '0;
        chip_run <= 1'b0;
      end else if (rise && !hold) begin
        if (step == 3'd5) begin
          step     <= '0;
          chip_go  <= is_chip;
          sect_go  <= is_sect;
          chip_run <= is_chip;
          if (is_sect) sect_id <= cap_sec;
        end else begin
          step <= hit ? step + 3'd1 : 3'd0;
        end
      end
    end
  end
endmodule

module flash_erase_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic eng_busy,
  input logic chip_run,
  input logic chip_go,
  input logic sect_go
);
  a_r4_chip_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    chip_go |=> !chip_go);
  a_r4_sect_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    sect_go |=> !sect_go);
  a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(chip_go && sect_go));
  a_r7_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |=> !(chip_go || sect_go));
  a_r6_run_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    chip_run |=> !(chip_go || sect_go));
endmodule

bind flash_erase_seq flash_erase_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .eng_busy(eng_busy), .chip_run(chip_run),
  .chip_go(chip_go), .sect_go(sect_go)
);

// File: tb/flash_erase_seq_tb.sv
module flash_erase_seq_tb_top;
  localparam int CB = 11;
  localparam int SB = 3;
  localparam int AW = CB + SB;

  logic clk = 1'b0, rst_n = 1'b0, we_n = 1'b1, eng_busy = 1'b0, eng_done = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] data = '0;
  logic chip_go, sect_go;
  logic [SB-1:0] sect_id;
  int checks = 0, errors = 0, chip_cnt = 0, sect_cnt = 0, c0 = 0, s0 = 0;

  always #10 clk = ~clk;

  flash_erase_seq #(.CMP_BITS(CB), .SECT_BITS(SB)) dut_i (
    .clk(clk), .rst_n(rst_n), .we_n(we_n), .addr(addr), .data(data),
    .eng_busy(eng_busy), .eng_done(eng_done),
    .chip_go(chip_go), .sect_go(sect_go), .sect_id(sect_id));

  always @(negedge clk) begin
    if (chip_go) chip_cnt++;
    if (sect_go) sect_cnt++;
  end

  function automatic logic [CB-1:0] pa(input int i);
    return (i == 1 || i == 4) ? CB'('h2AA) : CB'('h555);
  endfunction
  function automatic logic [7:0] pd(input int i);
    case (i)
      0, 3: return 8'hAA;
      1, 4: return 8'h55;
      default: return 8'h80;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic snap();
    c0 = chip_cnt; s0 = sect_cnt;
  endtask

  task automatic wr(input logic [AW-1:0] af, input logic [AW-1:0] ar, input logic [7:0] d);
    @(negedge clk); addr = af; data = d; we_n = 1'b0;
    repeat (4) @(negedge clk);
    addr = ar; we_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic unlock(input logic [SB-1:0] hi);
    for (int i = 0; i < 5; i++) wr({hi, pa(i)}, {hi, pa(i)}, pd(i));
  endtask

  task automatic done_pulse();
    @(negedge clk); eng_done = 1'b1; @(negedge clk); eng_done = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 chip_go reset", int'(chip_go), 0);
    chk("R9 sect_go reset", int'(sect_go), 0);
    chk("R9 sect_id reset", int'(sect_id), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 whole-array erase
    snap(); unlock(0); wr(AW'('h555), AW'('h555), 8'h10);
    chk("R1 chip pulse", chip_cnt - c0, 1);
    chk("R1 no sector pulse", sect_cnt - s0, 0);

    // R6 writes ignored while array erase runs
    snap(); unlock(0); wr({3'd4, CB'(7)}, {3'd4, CB'(7)}, 8'h30);
    chk("R6 sector ignored", sect_cnt - s0, 0);
    chk("R6 sect_id kept", int'(sect_id), 0);
    snap(); unlock(0); wr(AW'('h555), AW'('h555), 8'h10);
    chk("R6 chip ignored", chip_cnt - c0, 0);
    done_pulse();

    // R2/R10 sector sweep with noisy upper bits on unlock
    for (int s = 0; s < (1 << SB); s++) begin
      logic [AW-1:0] a;
      a = {SB'(s), CB'((s * 173 + 5) % (1 << CB))};
      snap(); unlock(SB'(s * 5 + 3)); wr(a, a, 8'h30);
      chk("R2 sector pulse", sect_cnt - s0, 1);
      chk("R2 sector no chip", chip_cnt - c0, 0);
      chk("R2 sector id", int'(sect_id), s);
      chk("R10 noisy upper bits", sect_cnt - s0, 1);
    end

    // R3 and R4: address moves while strobe low; no pulse before rise
    snap(); unlock(0);
    @(negedge clk); addr = {3'd5, CB'(9)}; data = 8'h30; we_n = 1'b0;
    repeat (3) @(negedge clk);
    addr = {3'd2, CB'(9)};
    repeat (6) @(negedge clk);
    chk("R4 no pulse while low", sect_cnt - s0, 0);
    we_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R4 pulse after rise", sect_cnt - s0, 1);
    chk("R3 fall address", int'(sect_id), 5);

    // R5 mismatch at each step, then the rest of the sequence
    for (int k = 0; k < 6; k++) begin
      snap();
      for (int i = 0; i < 6; i++) begin
        logic [7:0] d;
        d = (i == 5) ? 8'h10 : pd(i);
        if (i == k) d = d ^ 8'h01;
        wr({3'd0, pa(i)}, {3'd0, pa(i)}, d);
      end
      chk("R5 mismatch no chip", chip_cnt - c0, 0);
      chk("R5 mismatch no sector", sect_cnt - s0, 0);
    end
    snap(); unlock(0); wr({3'd0, CB'('h2AA)}, {3'd0, CB'('h2AA)}, 8'h10);
    chk("R5 chip code wrong address", chip_cnt - c0, 0);
    snap(); unlock(0); wr({3'd6, CB'(1)}, {3'd6, CB'(1)}, 8'h30);
    chk("R5 recovery", sect_cnt - s0, 1);

    // R7 busy holds off decoding
    eng_busy = 1'b1;
    snap(); unlock(0); wr({3'd3, CB'(0)}, {3'd3, CB'(0)}, 8'h30);
    chk("R7 busy no pulse", sect_cnt - s0, 0);
    eng_busy = 1'b0;
    snap(); unlock(0); wr({3'd3, CB'(0)}, {3'd3, CB'(0)}, 8'h30);
    chk("R7 after busy", sect_cnt - s0, 1);

    // R8 done resets a partial sequence
    snap();
    for (int i = 0; i < 3; i++) wr({3'd0, pa(i)}, {3'd0, pa(i)}, pd(i));
    done_pulse();
    for (int i = 3; i < 5; i++) wr({3'd0, pa(i)}, {3'd0, pa(i)}, pd(i));
    wr({3'd1, CB'(0)}, {3'd1, CB'(0)}, 8'h30);
    chk("R8 partial cleared", sect_cnt - s0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule